// File: doc/BRIEF.md
# NAND Sector Hamming ECC Corrector

This block judges one 512-byte NAND sector from its 24-bit row/column parity code. It receives two codes: the one read back from the spare area and the one recomputed over the data just read. Their bitwise XOR, the syndrome, is classified into one of four outcomes: clean, a single data bit in error (which can be fixed), an error confined to the stored code, or damage beyond repair. For a fixable error the block reports which byte of the sector holds the bad bit, and which bit of that byte.

The code pair arrives on a valid/ready stream and the verdict leaves on a second valid/ready stream. The output holds a single entry. A new pair is taken only when that entry is empty or is being consumed in the same cycle, so a stalled consumer stalls the producer with no loss of data. While `res_valid` is high and `res_ready` is low, the verdict stays frozen. The last verdict also stays on the `res_*` pins after it has been consumed, until the next pair is accepted.

A plain combinational correction port applies that last verdict to the data stream. The caller presents any sector byte with its address and gets the byte back, with the faulty bit inverted when the address matches a fixable error.

Top module: `hecc_corrector`

## Requirements
- R1: When the stored and recomputed codes are equal, the status is 0 (clean), and the reported byte address and bit index are both 0.
- R2: When every syndrome byte has bits 1:0, 3:2, 5:4 and 7:6 each holding two different values, the status is 1 (data fix). The byte address is then taken from the syndrome as follows, where syndrome byte 0 is syndrome bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16:
  - address bits 3..0 come from byte 0 bits 7,5,3,1;
  - address bits 4,5,6,7 come from byte 1 bits 1,3,5,7;
  - address bit 8 comes from byte 2 bit 1.
- R3: For status 1, the bit index (bit 2..0) is syndrome byte 2 bits 7,5,3.
- R4: A syndrome with exactly one of its 24 bits set gives status 2 (code error), with address and index 0.
- R5: Any other nonzero syndrome gives status 3 (uncorrectable), with address and index 0.
- R6: A pair accepted at a clock edge (`in_valid` and `in_ready` both high) shows as `res_valid` high, with its verdict, right after that edge.
- R7: While `res_valid` is high and `res_ready` is low, `in_ready` is low and the verdict on the `res_*` pins does not change.
- R8: When the held status is 1 and `fix_addr` equals the held byte address, `fix_out` is `fix_data` with the held bit index inverted.
- R9: In every other case `fix_out` equals `fix_data`.
- R10: After reset, `res_valid` is low, `in_ready` is high and the held status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Code pair offered |
| in_ready | output | 1 | Code pair can be taken this cycle |
| stored_code | input | 24 | Parity code read from the spare area |
| calc_code | input | 24 | Parity code recomputed from the data |
| res_valid | output | 1 | Verdict available |
| res_ready | input | 1 | Consumer takes the verdict |
| res_status | output | 2 | 0 clean, 1 data fix, 2 code error, 3 uncorrectable |
| res_byte_addr | output | 9 | Byte address of the bad bit |
| res_bit_idx | output | 3 | Bit index of the bad bit |
| fix_addr | input | 9 | Address of the byte to be corrected |
| fix_data | input | 8 | Byte to be corrected |
| fix_out | output | 8 | Corrected byte |

## Verification
A wrong classification or a swapped syndrome tap shows on the `res_*` pins in the cycle right after the pair is accepted. It reaches the data only through `fix_out`, where a flip lands on the wrong byte or bit, or on a byte that should pass through untouched. A broken one-entry handshake shows as a verdict that is lost, duplicated or changed while stalled. Comparing each verdict in order against the expected list exposes this at the first stall, and the correction port is tested against addresses that sit one step away from the decoded one.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int CODE_W    = 24;
  localparam int SYN_BYTES = CODE_W / 8;
  localparam int BIT_W     = 3;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_CODE   = 2'd2,
    ST_UNCORR = 2'd3
  } hecc_status_e;
endpackage

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
(
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output logic [CODE_W-1:0] syn,
  output hecc_status_e      verdict
);
  localparam int PAIRS = CODE_W / 2;

  logic [PAIRS-1:0] pair_split;

  assign syn = stored_code ^ calc_code;

  // one flag per adjacent bit pair; all must differ for a data fix
  genvar p;
  generate
    for (p = 0; p < PAIRS; p++) begin : g_pair
      assign pair_split[p] = syn[2*p] ^ syn[2*p+1];
    end
  endgenerate

  always_comb begin
    if (syn == '0)
      verdict = ST_CLEAN;
    else if (&pair_split)
      verdict = ST_FIXED;
    else if ($countones(syn) == 1)
      verdict = ST_CODE;
    else
      verdict = ST_UNCORR;
  end
endmodule

// File: rtl/hecc_locate.sv
module hecc_locate
  import hecc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [CODE_W-1:0] syn,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [BIT_W-1:0]  bit_idx
);
  // odd taps of each syndrome byte carry the position
  genvar k;
  generate
    for (k = 0; k < 4; k++) begin : g_lo
      assign byte_addr[k]   = syn[2*k+1];
      assign byte_addr[4+k] = syn[8+2*k+1];
    end
    for (k = 0; k < BIT_W; k++) begin : g_bit
      assign bit_idx[k] = syn[16+2*k+3];
    end
  endgenerate

  assign byte_addr[8] = syn[17];
endmodule

// File: rtl/hecc_flip.sv
module hecc_flip
  import hecc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  hecc_status_e      held_status,
  input  logic [ADDR_W-1:0] held_addr,
  input  logic [BIT_W-1:0]  held_bit,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [DATA_W-1:0] fix_data,
  output logic [DATA_W-1:0] fix_out
);
  logic             hit;
  logic [DATA_W-1:0] mask;

  assign hit  = (held_status == ST_FIXED) && (fix_addr == held_addr);
  assign mask = hit ? (DATA_W'(1) << held_bit) : '0;
  assign fix_out = fix_data ^ mask;
endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 8,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [23:0]       stored_code,
  input  logic [23:0]       calc_code,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_status,
  output logic [ADDR_W-1:0] res_byte_addr,
  output logic [BIT_W-1:0]  res_bit_idx,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [DATA_W-1:0] fix_data,
  output logic [DATA_W-1:0] fix_out
);
  logic [CODE_W-1:0] syn;
  hecc_status_e      verdict;
  logic [ADDR_W-1:0] loc_addr;
  logic [BIT_W-1:0]  loc_bit;

  hecc_status_e      st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              valid_q;
  logic              take;

  hecc_classify u_cls (
    .stored_code(stored_code),
    .calc_code  (calc_code),
    .syn        (syn),
    .verdict    (verdict)
  );

  hecc_locate #(.ADDR_W(ADDR_W)) u_loc (
    .syn      (syn),
    .byte_addr(loc_addr),
    .bit_idx  (loc_bit)
  );

  // single-entry output register: refill when empty or draining
  assign in_ready = !valid_q || res_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      st_q    <= ST_CLEAN;
      addr_q  <= '0;
      bit_q   <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      st_q    <= verdict;
      addr_q  <= (verdict == ST_FIXED) ? loc_addr : '0;
      bit_q   <= (verdict == ST_FIXED) ? loc_bit  : '0;
    end else if (res_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign res_valid     = valid_q;
  assign res_status    = st_q;
  assign res_byte_addr = addr_q;
  assign res_bit_idx   = bit_q;

  hecc_flip #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_flip (
    .held_status(st_q),
    .held_addr  (addr_q),
    .held_bit   (bit_q),
    .fix_addr   (fix_addr),
    .fix_data   (fix_data),
    .fix_out    (fix_out)
  );
endmodule

// File: rtl/hecc_checker.sv
module hecc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [23:0] stored_code,
  input logic [23:0] calc_code,
  input logic        res_valid,
  input logic        res_ready,
  input logic [1:0]  res_status,
  input logic [8:0]  res_byte_addr,
  input logic [2:0]  res_bit_idx,
  input logic [8:0]  fix_addr,
  input logic [7:0]  fix_data,
  input logic [7:0]  fix_out
);
  assert_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && stored_code == calc_code)
      |=> (res_status == 2'd0 && res_byte_addr == 9'd0 && res_bit_idx == 3'd0));

  assert_code_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && $countones(stored_code ^ calc_code) == 1)
      |=> (res_status == 2'd2));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready)
      |=> (res_valid && $stable(res_status) && $stable(res_byte_addr)
           && $stable(res_bit_idx)));

  assert_stall_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready);

  assert_flip_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_status == 2'd1 && fix_addr == res_byte_addr)
      |-> ($countones(fix_out ^ fix_data) == 1));

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_status != 2'd1 || fix_addr != res_byte_addr) |-> (fix_out == fix_data));
endmodule

bind hecc_corrector hecc_checker u_chk (.*);

// File: tb/sim_hecc_corrector.sv
`timescale 1ns/1ps
module sim_hecc_corrector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_status;
  logic [8:0]  res_byte_addr;
  logic [2:0]  res_bit_idx;
  logic [8:0]  fix_addr = '0;
  logic [7:0]  fix_data = '0;
  logic [7:0]  fix_out;

  int checks = 0;
  int errors = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;
  logic [13:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  hecc_corrector u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // syndrome for a single data-bit error at byte a, bit b (R2, R3 layout)
  function automatic logic [23:0] fix_syn(input int a, input int b);
    logic [23:0] s;
    s = '0;
    for (int k = 0; k < 4; k++) begin
      s[2*k+1]   = a[k];
      s[8+2*k+1] = a[4+k];
    end
    s[17] = a[8];
    for (int k = 0; k < 3; k++) s[16+2*k+3] = b[k];
    for (int k = 0; k < 12; k++) s[2*k] = ~s[2*k+1];
    return s;
  endfunction

  // driver: offers a pair, records the expected verdict when it is taken
  task automatic send(input logic [23:0] calc, input logic [23:0] syn,
                      input logic [1:0] st, input int a, input int b);
    @(negedge clk);
    in_valid = 1'b1;
    calc_code = calc;
    stored_code = calc ^ syn;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    exp_q.push_back({st, 9'(a), 3'(b)});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // back-pressure generator
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rand_ready) res_ready = lfsr[0];
  end

  // monitor: samples before the edge at which the transfer happens
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n && res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected verdict", 32'(res_status), 32'hFFFF);
        end else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          check("R1-5 status", 32'(res_status), 32'(e[13:12]));
          check("R2 byte address", 32'(res_byte_addr), 32'(e[11:3]));
          check("R3 bit index", 32'(res_bit_idx), 32'(e[2:0]));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 res_valid after reset", 32'(res_valid), 32'd0);
    check("R10 in_ready after reset", 32'(in_ready), 32'd1);
    check("R10 status after reset", 32'(res_status), 32'd0);
    rst_n = 1'b1;

    // phase 1: mixed patterns under random back-pressure
    rand_ready = 1'b1;
    send(24'h123456, 24'h000000, 2'd0, 0, 0);            // R1
    send(24'hFFFFFF, 24'h000000, 2'd0, 0, 0);            // R1
    send(24'h0F0F0F, fix_syn(0, 0), 2'd1, 0, 0);         // R2 R3 low corner
    send(24'h00A5C3, fix_syn(511, 7), 2'd1, 511, 7);     // R2 R3 high corner
    send(24'h777000, fix_syn(9'h155, 5), 2'd1, 9'h155, 5);
    send(24'h3C3C3C, fix_syn(9'h0AA, 2), 2'd1, 9'h0AA, 2);
    send(24'h000001, 24'h000001, 2'd2, 0, 0);            // R4
    send(24'h5A5A5A, 24'h002000, 2'd2, 0, 0);            // R4
    send(24'h111111, 24'h800000, 2'd2, 0, 0);            // R4
    send(24'h222222, 24'h000003, 2'd3, 0, 0);            // R5 pair equal
    send(24'h333333, 24'hFFFFFF, 2'd3, 0, 0);            // R5
    send(24'h444444, fix_syn(3, 1) ^ 24'h000100, 2'd3, 0, 0); // R5 one pair broken
    rand_ready = 1'b0;
    res_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 queue drained", 32'(exp_q.size()), 32'd0);

    // phase 2: latency and correction port
    send(24'h0, fix_syn(9'h155, 5), 2'd1, 9'h155, 5);
    #0.5;
    check("R6 valid right after accept", 32'(res_valid), 32'd1);
    repeat (2) @(negedge clk);
    fix_addr = 9'h155; fix_data = 8'h00;
    #1 check("R8 flip at decoded byte", 32'(fix_out), 32'h20);
    fix_data = 8'hFF;
    #1 check("R8 flip at decoded byte", 32'(fix_out), 32'hDF);
    fix_addr = 9'h154;
    #1 check("R9 neighbour byte passes", 32'(fix_out), 32'hFF);
    fix_addr = 9'h055;
    #1 check("R9 address bit 8 differs", 32'(fix_out), 32'hFF);
    send(24'h0, 24'h000400, 2'd2, 0, 0);
    repeat (2) @(negedge clk);
    fix_addr = 9'h000; fix_data = 8'h5A;
    #1 check("R9 code error leaves data", 32'(fix_out), 32'h5A);

    // phase 3: stall holds verdict and blocks input
    res_ready = 1'b0;
    send(24'h0, fix_syn(7, 6), 2'd1, 7, 6);
    @(negedge clk);
    in_valid = 1'b1;
    calc_code = 24'h0;
    stored_code = 24'h000001;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R7 in_ready low while stalled", 32'(in_ready), 32'd0);
      check("R7 verdict frozen", 32'(res_byte_addr), 32'd7);
      @(negedge clk);
    end
    in_valid = 1'b0;
    res_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 stalled verdict delivered once", 32'(exp_q.size()), 32'd0);
    check("R7 output emptied", 32'(res_valid), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule